// File: doc/BRIEF.md
# Bus Transaction Beat Sequencer

The sequencer takes one processor memory request at a time and turns it into a series of data-bus beats. Each request carries an address, a size code, a read/write flag and a flag marking a whole cache-line move. The data bus is either 32 or 64 bits wide. A strap input picks the width, and the sequencer samples it only while reset is held. Each beat puts out an address, byte-lane enables and a beat index. The memory side acknowledges each beat. After the final acknowledge, the sequencer pulses a completion flag for one cycle.

A line request always moves a 32-byte line, starting from the line-aligned address. In 32-bit mode this takes eight beats and in 64-bit mode four. A noncached request moves 1, 2, 3, 4 or 8 bytes. It takes one beat, except for an 8-byte request on the 32-bit bus, which is split into two word beats. A noncached request whose bytes do not fit within one bus word raises a one-cycle error pulse and issues no beats. An unknown size code does the same.

Top module: `beat_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `beat_valid`, `done` and `err` are 0.
- R2: The sequencer captures the bus width from `wide_strap` on clock edges while `rst_n` is low (1 = 64-bit, 0 = 32-bit). Later changes of the strap have no effect until the next reset.
- R3: In 32-bit mode, a line request (`req_line`=1, size code ignored) gives 8 beats. The addresses are `req_addr` with bits [4:0] cleared, then 4 higher on each beat. Every beat has lanes 8'h0F and the indices run 0 to 7.
- R4: In 64-bit mode, a line request gives 4 beats. They start at the line-aligned address and step by 8, with lanes 8'hFF and indices 0 to 3.
- R5: A noncached request with size code 0, 1, 2 or 3 (1, 2, 3 or 4 bytes) gives one beat. Its address is `req_addr` with the low log2(bus bytes) bits cleared. Its lanes are that many adjacent ones, shifted left by the address offset within the bus word.
- R6: In 32-bit mode, a noncached request with size code 4 (8 bytes) and `req_addr[2:0]`=0 gives two beats, at `req_addr` and `req_addr`+4, both with lanes 8'h0F.
- R7: In 64-bit mode, a noncached request with size code 4 and `req_addr[2:0]`=0 gives one beat at `req_addr` with lanes 8'hFF.
- R8: A noncached request that crosses a bus word raises `err` for one cycle, in the cycle after it is accepted, with no beat. So does a size code 4 request that is not 8-byte aligned, and any size code 5 to 7. `req_ready` returns in the cycle after that.
- R9: A beat holds its address, lanes and index until a cycle with `beat_ack`=1.
- R10: `beat_last` is high on the final beat only. `done` is high for exactly one cycle, in the cycle after the final acknowledge. `req_ready` returns in the cycle after `done`.
- R11: A request is accepted only while `req_ready` is 1. `req_valid` and request fields seen while busy do not change the beats in flight.
- R12: `beat_write` equals the `req_write` value of the accepted request for all of its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wide_strap | input | 1 | Bus width strap, sampled during reset (1 = 64-bit) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 3 | Size code: 0=1B, 1=2B, 2=3B, 3=4B, 4=8B |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | 1 | 1 = whole cache line, 0 = noncached |
| beat_valid | output | 1 | Beat presented to the bus |
| beat_addr | output | ADDR_W | Beat address |
| beat_lanes | output | 8 | Byte-lane enables |
| beat_idx | output | IDX_W | Beat index within the transfer |
| beat_last | output | 1 | Final beat marker |
| beat_write | output | 1 | Direction of the beat |
| beat_ack | input | 1 | Memory acknowledge of the current beat |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejected-request pulse |

## Verification
The assertions assume that `wide_strap` stays steady during the cycles where reset is held. They also assume that `beat_ack` only means something while a beat is shown, and that no request fields need to hold after acceptance. The bench keeps the strap fixed for the whole reset window and flips it only after release. It raises `beat_ack` only at a negative edge where a beat is visible, and it drops it one cycle later. Request fields that change while the sequencer is busy are part of the deliberate R11 stimulus, and the assertions do not depend on them.

// File: rtl/beat_seq_pkg.sv
package beat_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BEAT = 2'd1,
      ST_DONE = 2'd2,
      ST_ERR  = 2'd3
   } seq_state_e;

   localparam int MAX_BUS_BYTES = 8;

   // size code to byte count; 0 marks an unsupported code
   function automatic logic [3:0] size_to_bytes(input logic [2:0] code);
      case (code)
         3'd0:    return 4'd1;
         3'd1:    return 4'd2;
         3'd2:    return 4'd3;
         3'd3:    return 4'd4;
         3'd4:    return 4'd8;
         default: return 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/beat_decode.sv
module beat_decode
   import beat_seq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int IDX_W      = 3
) (
   input  logic                     wide,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [2:0]               size,
   input  logic                     line,
   output logic                     bad,
   output logic [ADDR_W-1:0]        base,
   output logic [3:0]               step,
   output logic [MAX_BUS_BYTES-1:0] lanes,
   output logic [IDX_W-1:0]         last_idx
);
   localparam int LINE_LSB = $clog2(LINE_BYTES);

   logic [3:0]               bus_bytes;
   logic [3:0]               offset;
   logic [3:0]               nbytes;
   logic [4:0]               span_end;
   logic [MAX_BUS_BYTES-1:0] sub_lanes;
   logic [MAX_BUS_BYTES-1:0] full_lanes;
   logic [ADDR_W-1:0]        word_base;

   assign bus_bytes  = wide ? 4'd8 : 4'd4;
   assign offset     = wide ? {1'b0, addr[2:0]} : {2'b00, addr[1:0]};
   assign nbytes     = size_to_bytes(size);
   assign span_end   = {1'b0, offset} + {1'b0, nbytes};
   assign full_lanes = wide ? 8'hFF : 8'h0F;
   assign word_base  = wide ? {addr[ADDR_W-1:3], 3'b000}
                            : {addr[ADDR_W-1:2], 2'b00};

   for (genvar i = 0; i < MAX_BUS_BYTES; i++) begin : g_lane
      assign sub_lanes[i] = (5'(i) >= {1'b0, offset}) &&
                            (5'(i) < span_end) &&
                            (5'(i) < {1'b0, bus_bytes});
   end

   always_comb begin
      bad      = 1'b0;
      base     = word_base;
      step     = 4'd4;
      lanes    = sub_lanes;
      last_idx = '0;
      if (line) begin
         base     = {addr[ADDR_W-1:LINE_LSB], LINE_LSB'(0)};
         step     = bus_bytes;
         lanes    = full_lanes;
         last_idx = wide ? IDX_W'(LINE_BYTES / 8 - 1) : IDX_W'(LINE_BYTES / 4 - 1);
      end else if (nbytes == 4'd0) begin
         bad = 1'b1;
      end else if (nbytes == 4'd8) begin
         bad      = (addr[2:0] != 3'b000);
         base     = addr;
         lanes    = full_lanes;
         last_idx = wide ? IDX_W'(0) : IDX_W'(1);
      end else begin
         bad = (span_end > {1'b0, bus_bytes});
      end
   end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] last_in,
   input  logic             adv,
   output logic [IDX_W-1:0] idx,
   output logic             is_last
);
   logic [IDX_W-1:0] last_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         last_r <= '0;
      end else if (load) begin
         idx    <= '0;
         last_r <= last_in;
      end else if (adv) begin
         idx <= idx + IDX_W'(1);
      end
   end

   assign is_last = (idx == last_r);
endmodule

// File: rtl/beat_seq.sv
module beat_seq
   import beat_seq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int IDX_W      = $clog2(LINE_BYTES / 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_strap,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic              req_write,
   input  logic              req_line,
   output logic              beat_valid,
   output logic [ADDR_W-1:0] beat_addr,
   output logic [7:0]        beat_lanes,
   output logic [IDX_W-1:0]  beat_idx,
   output logic              beat_last,
   output logic              beat_write,
   input  logic              beat_ack,
   output logic              done,
   output logic              err
);
   if (LINE_BYTES < 16 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_chk_line
      $error("beat_seq: LINE_BYTES must be a power of two, at least 16");
   end
   if (IDX_W < $clog2(LINE_BYTES / 4)) begin : g_chk_idx
      $error("beat_seq: IDX_W too narrow for the beat count");
   end
   if (ADDR_W < $clog2(LINE_BYTES) + 1) begin : g_chk_addr
      $error("beat_seq: ADDR_W too narrow");
   end

   seq_state_e               st;
   logic                     mode_wide;
   logic [ADDR_W-1:0]        cur_addr;
   logic [3:0]               step_r;
   logic [MAX_BUS_BYTES-1:0] lanes_r;
   logic                     write_r;

   logic                     dec_bad;
   logic [ADDR_W-1:0]        dec_base;
   logic [3:0]               dec_step;
   logic [MAX_BUS_BYTES-1:0] dec_lanes;
   logic [IDX_W-1:0]         dec_last;
   logic                     accept;
   logic                     advance;
   logic                     idx_last;

   // width strap is captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) mode_wide <= wide_strap;
   end

   beat_decode #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)
   ) u_dec (
      .wide(mode_wide), .addr(req_addr), .size(req_size), .line(req_line),
      .bad(dec_bad), .base(dec_base), .step(dec_step),
      .lanes(dec_lanes), .last_idx(dec_last)
   );

   assign accept  = (st == ST_IDLE) && req_valid;
   assign advance = (st == ST_BEAT) && beat_ack;

   beat_counter #(.IDX_W(IDX_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(accept), .last_in(dec_last),
      .adv(advance), .idx(beat_idx), .is_last(idx_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cur_addr <= '0;
         step_r   <= '0;
         lanes_r  <= '0;
         write_r  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               st       <= dec_bad ? ST_ERR : ST_BEAT;
               cur_addr <= dec_base;
               step_r   <= dec_step;
               lanes_r  <= dec_lanes;
               write_r  <= req_write;
            end
            ST_BEAT: if (beat_ack) begin
               if (idx_last) st <= ST_DONE;
               else          cur_addr <= cur_addr + ADDR_W'(step_r);
            end
            ST_DONE: st <= ST_IDLE;
            ST_ERR:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (st == ST_IDLE);
   assign beat_valid = (st == ST_BEAT);
   assign beat_addr  = cur_addr;
   assign beat_lanes = lanes_r;
   assign beat_last  = beat_valid && idx_last;
   assign beat_write = write_r;
   assign done       = (st == ST_DONE);
   assign err        = (st == ST_ERR);
endmodule

// File: rtl/beat_seq_chk.sv
module beat_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_wide,
   input logic              req_valid,
   input logic              req_ready,
   input logic              beat_valid,
   input logic [ADDR_W-1:0] beat_addr,
   input logic [7:0]        beat_lanes,
   input logic [IDX_W-1:0]  beat_idx,
   input logic              beat_last,
   input logic              beat_ack,
   input logic              done,
   input logic              err
);
   assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mode_wide));

   assert_narrow_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !mode_wide) |-> (beat_lanes[7:4] == 4'h0));

   assert_lanes_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> (beat_lanes != 8'h00));

   assert_err_nobeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!beat_valid && $past(req_valid && req_ready)));

   assert_err_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> (req_ready && !err));

   assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_ack) |=>
         (beat_valid && $stable(beat_addr) && $stable(beat_lanes) && $stable(beat_idx)));

   assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(beat_valid && beat_ack && beat_last));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(beat_valid || done || err));
endmodule

bind beat_seq beat_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide),
   .req_valid(req_valid), .req_ready(req_ready),
   .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_lanes(beat_lanes),
   .beat_idx(beat_idx), .beat_last(beat_last), .beat_ack(beat_ack),
   .done(done), .err(err)
);

// File: tb/sim_beat_seq.sv
module sim_beat_seq;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct packed {
      logic        wide;
      logic        line;
      logic [2:0]  sz;
      logic [31:0] addr;
      logic        xerr;
      logic [3:0]  nb;
      logic [31:0] a0;
      logic [3:0]  step;
      logic [7:0]  lanes;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b1, 3'd7, 32'h1000_0013, 1'b0, 4'd8, 32'h1000_0000, 4'd4, 8'h0F}, // R3
      '{1'b0, 1'b0, 3'd0, 32'h0000_0023, 1'b0, 4'd1, 32'h0000_0020, 4'd4, 8'h08}, // R5
      '{1'b0, 1'b0, 3'd1, 32'h0000_0042, 1'b0, 4'd1, 32'h0000_0040, 4'd4, 8'h0C}, // R5
      '{1'b0, 1'b0, 3'd2, 32'h0000_0051, 1'b0, 4'd1, 32'h0000_0050, 4'd4, 8'h0E}, // R5
      '{1'b0, 1'b0, 3'd2, 32'h0000_0052, 1'b1, 4'd0, 32'h0,         4'd0, 8'h00}, // R8
      '{1'b0, 1'b0, 3'd3, 32'h0000_0060, 1'b0, 4'd1, 32'h0000_0060, 4'd4, 8'h0F}, // R5
      '{1'b0, 1'b0, 3'd4, 32'h0000_0078, 1'b0, 4'd2, 32'h0000_0078, 4'd4, 8'h0F}, // R6
      '{1'b0, 1'b0, 3'd4, 32'h0000_0084, 1'b1, 4'd0, 32'h0,         4'd0, 8'h00}, // R8
      '{1'b0, 1'b0, 3'd5, 32'h0000_0090, 1'b1, 4'd0, 32'h0,         4'd0, 8'h00}, // R8
      '{1'b1, 1'b1, 3'd0, 32'h0000_003F, 1'b0, 4'd4, 32'h0000_0020, 4'd8, 8'hFF}, // R4
      '{1'b1, 1'b0, 3'd2, 32'h0000_0105, 1'b0, 4'd1, 32'h0000_0100, 4'd8, 8'hE0}, // R5
      '{1'b1, 1'b0, 3'd2, 32'h0000_0106, 1'b1, 4'd0, 32'h0,         4'd0, 8'h00}, // R8
      '{1'b1, 1'b0, 3'd4, 32'h0000_0208, 1'b0, 4'd1, 32'h0000_0208, 4'd8, 8'hFF}, // R7
      '{1'b1, 1'b0, 3'd4, 32'h0000_020C, 1'b1, 4'd0, 32'h0,         4'd0, 8'h00}, // R8
      '{1'b1, 1'b0, 3'd3, 32'h0000_030C, 1'b0, 4'd1, 32'h0000_0308, 4'd8, 8'hF0}, // R5
      '{1'b1, 1'b0, 3'd1, 32'h0000_000B, 1'b0, 4'd1, 32'h0000_0008, 4'd8, 8'h18}  // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_strap = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic        req_line = 1'b0;
   logic        beat_valid;
   logic [31:0] beat_addr;
   logic [7:0]  beat_lanes;
   logic [2:0]  beat_idx;
   logic        beat_last;
   logic        beat_write;
   logic        beat_ack = 1'b0;
   logic        done;
   logic        err;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   beat_seq u0 (
      .clk(clk), .rst_n(rst_n), .wide_strap(wide_strap),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_line(req_line),
      .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_lanes(beat_lanes),
      .beat_idx(beat_idx), .beat_last(beat_last), .beat_write(beat_write),
      .beat_ack(beat_ack), .done(done), .err(err)
   );

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic do_reset(input logic wide);
      rst_n      = 1'b0;
      wide_strap = wide;
      req_valid  = 1'b0;
      beat_ack   = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", 64'(req_ready), 64'd1);
      chk("R1 quiet in reset", 64'({beat_valid, done, err}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", 64'(req_ready), 64'd1);
      chk("R1 quiet after reset", 64'({beat_valid, done, err}), 64'd0);
      wide_strap = ~wide; // R2: must be ignored from here on
   endtask

   task automatic run_vec(input vec_t v, input logic wr);
      @(negedge clk);
      req_addr  = v.addr;
      req_size  = v.sz;
      req_line  = v.line;
      req_write = wr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11 ready low when busy", 64'(req_ready), 64'd0);
      if (v.xerr) begin
         chk("R8 err pulse", 64'({err, beat_valid}), 64'b10);
         @(negedge clk);
         chk("R8 err drops, ready back", 64'({err, req_ready}), 64'b01);
      end else begin
         for (int k = 0; k < int'(v.nb); k++) begin
            chk("R3/R4/R5/R6/R7 beat valid", 64'(beat_valid), 64'd1);
            chk("R3/R4/R5/R6/R7 beat addr", 64'(beat_addr), 64'(v.a0 + 32'(k) * 32'(v.step)));
            chk("R3/R4/R5/R6/R7 beat lanes", 64'(beat_lanes), 64'(v.lanes));
            chk("R3/R4 beat index", 64'(beat_idx), 64'(k));
            chk("R10 last marker", 64'(beat_last), 64'(k == int'(v.nb) - 1));
            chk("R12 beat write", 64'(beat_write), 64'(wr));
            if (k == 1) begin
               @(negedge clk); // stall one cycle with no acknowledge
               chk("R9 held addr", 64'(beat_addr), 64'(v.a0 + 32'(k) * 32'(v.step)));
               chk("R9 held index", 64'({beat_valid, beat_idx}), 64'({1'b1, 3'(k)}));
            end
            beat_ack = 1'b1;
            @(negedge clk);
            beat_ack = 1'b0;
         end
         chk("R10 done pulse", 64'({done, beat_valid}), 64'b10);
         @(negedge clk);
         chk("R10 done one cycle, ready back", 64'({done, req_ready}), 64'b01);
      end
   endtask

   initial begin
      logic cur_mode;
      do_reset(1'b0);
      cur_mode = 1'b0;
      // R2: strap is now 1 but mode stays 32-bit
      chk("R2 strap change ignored", 64'(wide_strap), 64'd1);
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wide != cur_mode) begin
            do_reset(VEC[i].wide);
            cur_mode = VEC[i].wide;
         end
         run_vec(VEC[i], 1'(i % 2));
      end

      // R11: request held high and fields changed while busy
      do_reset(1'b0);
      @(negedge clk);
      req_addr = 32'h0000_0400; req_line = 1'b1; req_write = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_addr = 32'h0000_0800; req_line = 1'b0; req_size = 3'd0; req_write = 1'b0;
      for (int k = 0; k < 8; k++) begin
         chk("R11 beats unchanged by busy request", 64'(beat_addr), 64'(32'h400 + 32'(4 * k)));
         chk("R11 R12 write kept", 64'(beat_write), 64'd1);
         beat_ack = 1'b1;
         @(negedge clk);
         beat_ack = 1'b0;
      end
      chk("R10 done after busy request", 64'(done), 64'd1);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R11 idle after drop", 64'({req_ready, beat_valid}), 64'b10);
      @(negedge clk);
      chk("R11 no late accept", 64'({req_ready, beat_valid, err}), 64'b100);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule